// File: doc/BRIEF.md
# Addressing-Mode Operand Execution Unit

This block executes one two-operand add per request. The instruction names a destination register, a 3-bit mode code, up to two source registers, a constant and an access size. The unit forms the second operand under one of seven addressing modes. It reads byte-addressed data memory through a request/response port when the mode needs it, and it adds that operand to the destination register. The sum goes back into the same destination register. The destination is both the first source and the result.

Memory operands are checked for natural alignment before every read. The memory-indirect mode chains two dependent reads: a full-word pointer fetch, then an operand fetch at the address that came back. An illegal mode or a misaligned address ends the instruction with the error flag set and no write-back. The caller raises `start` for one cycle while the unit is idle. It then waits for the one-cycle `done` pulse. The write-back port shows each register update as it happens.

Top module: `amx_exec`

## Requirements
- R1: After reset `busy`, `done`, `err`, `wb_valid` and `mreq_valid` are low, and every register holds zero.
- R2: Mode code 0 (register) uses the contents of register `src_a` as the operand and issues no memory request.
- R3: Mode code 1 (immediate) uses `instr_const` as the operand and issues no memory request.
- R4: Mode code 2 (displacement) reads at `instr_const` plus register `src_a`. For example, a base of 400 with a constant of 4 reads address 404.
- R5: Mode code 3 (register deferred) reads at the contents of register `src_a`.
- R6: Mode code 4 (indexed) reads at register `src_a` plus register `src_b`. For example, 16 plus 3 reads address 19.
- R7: Mode code 5 (direct) reads at the address given by `instr_const`.
- R8: Mode code 6 (memory indirect) first reads an 8-byte pointer at the contents of register `src_a`. It then reads the operand at the returned pointer value, so two requests are issued in that order.
- R9: On success the destination register becomes its old value plus the operand, modulo 2^64. The new value is shown on `wb_data` with `wb_valid` high and `wb_reg` naming the register, in the cycle `done` is high.
- R10: A memory operand is 2^`instr_size` bytes (`instr_size` 0..3 gives 1, 2, 4 or 8 bytes). It is taken zero-extended from the low bytes of `mrsp_data`.
- R11: An access of s bytes at address A is allowed only when A mod s equals 0, so single-byte accesses always pass. A misaligned operand address, pointer address or returned pointer ends the instruction. In that case `err` and `done` are high, no further request is issued and the register is not written.
- R12: Mode code 7 is illegal. It raises `err` with `done`, issues no request and leaves every register unchanged.
- R13: `busy` is high from the cycle after `start` is accepted through the cycle in which `done` pulses. `done` lasts one cycle. A request holds its valid and address until `mreq_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| instr_mode | input | 3 | Addressing mode code |
| instr_dst | input | 4 | Destination and first-source register |
| instr_src_a | input | 4 | Source or base register |
| instr_src_b | input | 4 | Index register |
| instr_const | input | 64 | Constant field |
| instr_size | input | 2 | log2 of operand access size in bytes |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With done: instruction aborted |
| mreq_valid | output | 1 | Memory read request valid |
| mreq_ready | input | 1 | Memory accepts request |
| mreq_addr | output | 64 | Byte address of the read |
| mrsp_valid | input | 1 | Read data strobe |
| mrsp_data | input | 64 | Read data |
| wb_valid | output | 1 | Register write-back this cycle |
| wb_reg | output | 4 | Register being written |
| wb_data | output | 64 | Value written |

## Verification
The bench builds the unit with its default parameters: 16 registers of 64 bits. This lets every alignment outcome be reached with small addresses. Every size is swept against every low-order offset of a displacement address. Each mode is exercised with base values picked so that the expected address, such as 404 or 19, and the sized memory operand follow by arithmetic from a memory model whose content is a function of the address. A stalling ready pattern and a pointer offset that can be changed per test reach the request-hold behaviour and the misaligned second read of the indirect mode.

// File: rtl/amx_pkg.sv
package amx_pkg;

   typedef enum logic [2:0] {
      MD_REG  = 3'd0,
      MD_IMM  = 3'd1,
      MD_DISP = 3'd2,
      MD_DEF  = 3'd3,
      MD_IDX  = 3'd4,
      MD_DIR  = 3'd5,
      MD_IND  = 3'd6,
      MD_ILL  = 3'd7
   } amx_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEC,
      ST_REQ1,
      ST_WAIT1,
      ST_REQ2,
      ST_WAIT2,
      ST_WB,
      ST_FAIL
   } amx_state_e;

   localparam logic [1:0] PTR_SIZE = 2'd3;

endpackage

// File: rtl/amx_regfile.sv
module amx_regfile #(
   parameter int NREG   = 16,
   parameter int DATA_W = 64,
   localparam int IW    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IW-1:0]     ra_dst,
   input  logic [IW-1:0]     ra_a,
   input  logic [IW-1:0]     ra_b,
   output logic [DATA_W-1:0] rd_dst,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);

   logic [DATA_W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (we && waddr == IW'(i))
            regs[i] <= wdata;
      end
   end

   assign rd_dst = regs[ra_dst];
   assign rd_a   = regs[ra_a];
   assign rd_b   = regs[ra_b];

   // R9: a write lands in the addressed register on the next cycle
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we && ra_dst == waddr |=> rd_dst == $past(wdata));

endmodule

// File: rtl/amx_agen.sv
module amx_agen
   import amx_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  amx_mode_e         mode,
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] index,
   input  logic [DATA_W-1:0] konst,
   output logic [DATA_W-1:0] addr,
   output logic              uses_mem
);

   always_comb begin
      unique case (mode)
         MD_DISP: addr = konst + base;
         MD_IDX:  addr = base + index;
         MD_DIR:  addr = konst;
         default: addr = base;
      endcase
   end

   assign uses_mem = (mode inside {MD_DISP, MD_DEF, MD_IDX, MD_DIR, MD_IND});

endmodule

// File: rtl/amx_align.sv
module amx_align (
   input  logic [2:0] addr_lo,
   input  logic [1:0] size_log2,
   output logic       ok
);

   always_comb begin
      unique case (size_log2)
         2'd0: ok = 1'b1;
         2'd1: ok = ~addr_lo[0];
         2'd2: ok = (addr_lo[1:0] == 2'b00);
         default: ok = (addr_lo == 3'b000);
      endcase
   end

endmodule

// File: rtl/amx_sizer.sv
module amx_sizer #(
   parameter int DATA_W = 64,
   localparam int NBYTE = DATA_W / 8
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [1:0]        size_log2,
   output logic [DATA_W-1:0] value
);

   for (genvar i = 0; i < NBYTE; i++) begin : g_byte
      localparam int NEED = (i == 0) ? 0 : $clog2(i + 1);
      if (NEED > 3) begin : g_drop
         assign value[8*i +: 8] = 8'h00;
      end else begin : g_keep
         assign value[8*i +: 8] = (int'(size_log2) >= NEED) ? raw[8*i +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/amx_exec.sv
module amx_exec
   import amx_pkg::*;
#(
   parameter int NREG   = 16,
   parameter int DATA_W = 64,
   localparam int IW    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        instr_mode,
   input  logic [IW-1:0]     instr_dst,
   input  logic [IW-1:0]     instr_src_a,
   input  logic [IW-1:0]     instr_src_b,
   input  logic [DATA_W-1:0] instr_const,
   input  logic [1:0]        instr_size,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              mreq_valid,
   input  logic              mreq_ready,
   output logic [DATA_W-1:0] mreq_addr,
   input  logic              mrsp_valid,
   input  logic [DATA_W-1:0] mrsp_data,
   output logic              wb_valid,
   output logic [IW-1:0]     wb_reg,
   output logic [DATA_W-1:0] wb_data
);

   if (DATA_W < 64 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("amx_exec: DATA_W must be a byte multiple of at least 64");
   end
   if (NREG < 2 || (1 << IW) != NREG) begin : g_bad_nreg
      $error("amx_exec: NREG must be a power of two");
   end

   amx_state_e        state_q;
   amx_mode_e         mode_q;
   logic [IW-1:0]     dst_q, a_q, b_q;
   logic [DATA_W-1:0] k_q, addr_q, opnd_q;
   logic [1:0]        sz_q;

   logic [DATA_W-1:0] rd_dst, rd_a, rd_b;
   logic [DATA_W-1:0] ag_addr, chk_addr, sized;
   logic              ag_mem, al_ok;
   logic [1:0]        chk_size;

   amx_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wb_valid),
      .waddr  (wb_reg),
      .wdata  (wb_data),
      .ra_dst (dst_q),
      .ra_a   (a_q),
      .ra_b   (b_q),
      .rd_dst (rd_dst),
      .rd_a   (rd_a),
      .rd_b   (rd_b)
   );

   amx_agen #(.DATA_W(DATA_W)) u_agen (
      .mode     (mode_q),
      .base     (rd_a),
      .index    (rd_b),
      .konst    (k_q),
      .addr     (ag_addr),
      .uses_mem (ag_mem)
   );

   // one checker serves both the first address and the returned pointer
   always_comb begin
      if (state_q == ST_WAIT1) begin
         chk_addr = mrsp_data;
         chk_size = sz_q;
      end else begin
         chk_addr = ag_addr;
         chk_size = (mode_q == MD_IND) ? PTR_SIZE : sz_q;
      end
   end

   amx_align u_align (
      .addr_lo   (chk_addr[2:0]),
      .size_log2 (chk_size),
      .ok        (al_ok)
   );

   amx_sizer #(.DATA_W(DATA_W)) u_sizer (
      .raw       (mrsp_data),
      .size_log2 (sz_q),
      .value     (sized)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MD_REG;
         dst_q   <= '0;
         a_q     <= '0;
         b_q     <= '0;
         k_q     <= '0;
         sz_q    <= '0;
         addr_q  <= '0;
         opnd_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               mode_q  <= amx_mode_e'(instr_mode);
               dst_q   <= instr_dst;
               a_q     <= instr_src_a;
               b_q     <= instr_src_b;
               k_q     <= instr_const;
               sz_q    <= instr_size;
               state_q <= ST_DEC;
            end
            ST_DEC: begin
               if (mode_q == MD_REG) begin
                  opnd_q  <= rd_a;
                  state_q <= ST_WB;
               end else if (mode_q == MD_IMM) begin
                  opnd_q  <= k_q;
                  state_q <= ST_WB;
               end else if (!ag_mem || !al_ok) begin
                  state_q <= ST_FAIL;
               end else begin
                  addr_q  <= ag_addr;
                  state_q <= ST_REQ1;
               end
            end
            ST_REQ1: if (mreq_ready) state_q <= ST_WAIT1;
            ST_WAIT1: if (mrsp_valid) begin
               if (mode_q != MD_IND) begin
                  opnd_q  <= sized;
                  state_q <= ST_WB;
               end else if (!al_ok) begin
                  state_q <= ST_FAIL;
               end else begin
                  addr_q  <= mrsp_data;
                  state_q <= ST_REQ2;
               end
            end
            ST_REQ2: if (mreq_ready) state_q <= ST_WAIT2;
            ST_WAIT2: if (mrsp_valid) begin
               opnd_q  <= sized;
               state_q <= ST_WB;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_WB) || (state_q == ST_FAIL);
   assign err        = (state_q == ST_FAIL);
   assign mreq_valid = (state_q == ST_REQ1) || (state_q == ST_REQ2);
   assign mreq_addr  = addr_q;
   assign wb_valid   = (state_q == ST_WB);
   assign wb_reg     = dst_q;
   assign wb_data    = rd_dst + opnd_q;

   // R13: done is a single-cycle pulse inside the busy window
   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r13_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   // R13: an unaccepted request keeps valid and address
   a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr));
   // R11: operand requests leave the port only when naturally aligned
   a_r11_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && !(state_q == ST_REQ1 && mode_q == MD_IND)
      |-> (mreq_addr[2:0] & 3'((4'd1 << sz_q) - 4'd1)) == 3'd0);
   // R12: an illegal mode never reaches memory
   a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mode_q == MD_ILL |-> !mreq_valid);
   // R11: an aborted instruction writes nothing
   a_r11_err_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !wb_valid);

endmodule

// File: tb/amx_exec_bench.sv
module amx_exec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  instr_mode = '0;
   logic [3:0]  instr_dst = '0, instr_src_a = '0, instr_src_b = '0;
   logic [63:0] instr_const = '0;
   logic [1:0]  instr_size = '0;
   logic        busy, done, err, mreq_valid, wb_valid;
   logic        mreq_ready = 1'b0;
   logic        mrsp_valid = 1'b0;
   logic [63:0] mrsp_data = '0;
   logic [63:0] mreq_addr, wb_data;
   logic [3:0]  wb_reg;

   always #4 clk = ~clk;   // 125 MHz

   amx_exec u_amx_exec (
      .clk(clk), .rst_n(rst_n), .start(start), .instr_mode(instr_mode),
      .instr_dst(instr_dst), .instr_src_a(instr_src_a), .instr_src_b(instr_src_b),
      .instr_const(instr_const), .instr_size(instr_size), .busy(busy), .done(done),
      .err(err), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
      .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .wb_valid(wb_valid),
      .wb_reg(wb_reg), .wb_data(wb_data)
   );

   int          checks = 0, errors = 0;
   logic [63:0] model [16];
   logic [63:0] tweak = '0;
   int          nreq = 0;
   logic [63:0] req_log [4];
   logic        pend = 1'b0;
   logic [63:0] pend_addr = '0;
   int          stall = 0;
   int          cyc = 0;
   logic        g_err, g_wb;
   logic [63:0] g_data;
   logic [3:0]  g_reg;

   function automatic logic [63:0] memf(logic [63:0] a);
      return (a << 4) + 64'h100 + tweak;
   endfunction

   function automatic logic [63:0] szmask(logic [63:0] v, int sz);
      if (sz == 3) return v;
      return v & ((64'd1 << (8 * (1 << sz))) - 64'd1);
   endfunction

   // memory model: stalls one cycle in three, answers one cycle after acceptance
   always @(negedge clk) begin
      mrsp_valid = 1'b0;
      if (pend) begin
         mrsp_valid = 1'b1;
         mrsp_data  = memf(pend_addr);
         pend       = 1'b0;
      end
      stall = stall + 1;
      mreq_ready = (stall % 3 != 0);
      if (mreq_valid && mreq_ready) begin
         pend      = 1'b1;
         pend_addr = mreq_addr;
         if (nreq < 4) req_log[nreq] = mreq_addr;
         nreq = nreq + 1;
      end
   end

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog: R13 run did not finish, actual %0d cycles expected < 150000", cyc);
         summary();
      end
   end

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // issue one instruction and collect its outcome
   task automatic run(int md, int d, int a, int b, logic [63:0] k, int sz);
      int n;
      @(negedge clk);
      nreq        = 0;
      start       = 1'b1;
      instr_mode  = 3'(md);
      instr_dst   = 4'(d);
      instr_src_a = 4'(a);
      instr_src_b = 4'(b);
      instr_const = k;
      instr_size  = 2'(sz);
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R13 busy after start", 64'(busy), 64'd1);
      n = 0;
      while (done !== 1'b1 && n < 200) begin
         @(negedge clk);
         n = n + 1;
      end
      g_err  = err;
      g_wb   = wb_valid;
      g_data = wb_data;
      g_reg  = wb_reg;
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R13 done one cycle then idle",
          {busy, done}, 64'd0);
   endtask

   // run and compare against arithmetic expectation
   task automatic exec(string req, int md, int d, int a, int b, logic [63:0] k, int sz,
                       bit exp_err, int exp_nreq, logic [63:0] a0, logic [63:0] a1,
                       logic [63:0] opnd);
      logic [63:0] expv;
      run(md, d, a, b, k, sz);
      chk(g_err === exp_err, {req, " error flag"}, 64'(g_err), 64'(exp_err));
      chk(nreq == exp_nreq, {req, " request count"}, 64'(nreq), 64'(exp_nreq));
      if (exp_nreq > 0 && nreq > 0)
         chk(req_log[0] === a0, {req, " first address"}, req_log[0], a0);
      if (exp_nreq > 1 && nreq > 1)
         chk(req_log[1] === a1, {req, " second address"}, req_log[1], a1);
      if (exp_err) begin
         chk(g_wb === 1'b0, {req, " R11 no write-back"}, 64'(g_wb), 64'd0);
      end else begin
         expv = model[d] + opnd;
         chk(g_wb === 1'b1 && g_reg == 4'(d) && g_data === expv,
             {req, " R9 write-back value"}, g_data, expv);
         model[d] = expv;
      end
   endtask

   task automatic load(int d, logic [63:0] v);
      exec("R3 immediate", 1, d, 0, 0, v - model[d], 0, 1'b0, 0, 0, 0, v - model[d]);
   endtask

   initial begin
      logic [63:0] ad, ptr;
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && err === 0 && mreq_valid === 0 && wb_valid === 0,
          "R1 reset outputs", {busy, done, err, mreq_valid, wb_valid}, 64'd0);
      rst_n = 1'b1;
      // R1: registers start at zero, observed through register-mode adds
      for (int r = 0; r < 16; r++)
         exec("R1 R2 zero register", 0, r, (r + 5) % 16, 0, 64'h0, 0, 1'b0, 0, 0, 0, 64'h0);

      load(1, 64'd400);
      load(2, 64'd16);
      load(3, 64'd3);
      for (int r = 4; r < 16; r++) load(r, 64'(r * 64 + 8));

      // R2: register mode across source/destination pairs
      for (int d = 8; d < 12; d++)
         for (int a = 4; a < 8; a++)
            exec("R2 register", 0, d, a, 0, 64'hdead, 0, 1'b0, 0, 0, 0, model[a]);

      // R4 R10 R11: displacement with every size and low offset
      for (int sz = 0; sz < 4; sz++)
         for (int k = 0; k < 8; k++) begin
            ad = 64'd400 + 64'(k);
            if ((ad % (64'd1 << sz)) == 0)
               exec("R4 R10 displacement", 2, 12, 1, 0, 64'(k), sz, 1'b0, 1, ad, 0,
                    szmask(memf(ad), sz));
            else
               exec("R11 misaligned displacement", 2, 12, 1, 0, 64'(k), sz, 1'b1, 0, 0, 0, 0);
         end
      exec("R4 displacement 404", 2, 13, 1, 0, 64'd4, 2, 1'b0, 1, 64'd404, 0,
           szmask(memf(64'd404), 2));

      // R5: register deferred
      for (int a = 4; a < 8; a++)
         exec("R5 deferred", 3, 14, a, 0, 64'h77, 3, 1'b0, 1, model[a], 0,
              memf(model[a]));

      // R6: indexed
      exec("R6 indexed 19", 4, 15, 2, 3, 64'h0, 0, 1'b0, 1, 64'd19, 0,
           szmask(memf(64'd19), 0));
      exec("R6 R11 indexed misaligned", 4, 15, 2, 3, 64'h0, 1, 1'b1, 0, 0, 0, 0);

      // R7: direct
      for (int k = 64; k < 68; k++)
         for (int sz = 0; sz < 2; sz++) begin
            if ((k % (1 << sz)) == 0)
               exec("R7 direct", 5, 9, 0, 0, 64'(k), sz, 1'b0, 1, 64'(k), 0,
                    szmask(memf(64'(k)), sz));
            else
               exec("R7 R11 direct misaligned", 5, 9, 0, 0, 64'(k), sz, 1'b1, 0, 0, 0, 0);
         end

      // R8: memory indirect, two chained reads
      tweak = 64'd0;
      ptr = memf(64'd400);
      exec("R8 indirect", 6, 10, 1, 0, 64'h0, 3, 1'b0, 2, 64'd400, ptr, memf(ptr));
      tweak = 64'd2;
      ptr = memf(64'd400);
      exec("R8 indirect halfword", 6, 10, 1, 0, 64'h0, 1, 1'b0, 2, 64'd400, ptr,
           szmask(memf(ptr), 1));
      exec("R11 indirect second read misaligned", 6, 10, 1, 0, 64'h0, 2, 1'b1, 1,
           64'd400, 0, 0);
      tweak = 64'd0;
      exec("R11 indirect pointer misaligned", 6, 10, 3, 0, 64'h0, 0, 1'b1, 0, 0, 0, 0);

      // R12: illegal mode, then show the destination kept its value
      exec("R12 illegal mode", 7, 11, 1, 2, 64'h5, 0, 1'b1, 0, 0, 0, 0);
      exec("R12 destination unchanged", 1, 11, 0, 0, 64'h0, 0, 1'b0, 0, 0, 0, 64'h0);

      // R9: wrap modulo 2^64
      load(7, 64'hFFFF_FFFF_FFFF_FFFF);
      exec("R9 wraparound", 1, 7, 0, 0, 64'd2, 0, 1'b0, 0, 0, 0, 64'd2);

      summary();
   end

endmodule